// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static memory that takes one command on every enabled clock edge and puts no idle cycles between reads and writes, in either direction. Address, control and byte enables are registered on the command edge. Write data is registered two enabled edges later, which is also when read data appears on the registered output. Because both directions have the same two-edge delay, the shared data bus stays busy on every cycle. A one-entry forwarding path covers the single case the array itself would miss: a read that follows a write to the same word on the next cycle. Any other mix of reads and writes sees the newest data straight from the array.

A cycle is a real access only when the three chip selects agree and the sleep input is low. A load cycle (advance low) starts a new command. An advance cycle (advance high) steps a 2-bit counter over the two low address bits and keeps the direction that was loaded. The order is either linear or interleaved, chosen on the load cycle. The active-low clock enable freezes the whole pipeline.

Top module: `zbt_sram`

## Requirements
- R1: After rst_ni is released, rvalid_o is 0, rdata_o is all zero, and no burst is active.
- R2: Any sequence of reads and writes, one per enabled cycle, runs with no idle cycles. Every read returns the last data written to its address in command order.
- R3: A cycle is selected only when cs1_ni=0, cs2_i=1 and cs3_ni=0. Any other combination does no access, leaves memory unchanged and ends a burst.
- R4: While cke_ni=1, no state changes, rvalid_o and rdata_o hold, and the cycle is not a command.
- R5: A selected cycle with adv_i=1 continues the active burst in the loaded direction. With linear order, the low two address bits are (base+count) mod 4. The upper address bits stay fixed and the count wraps after four beats.
- R6: When ilv_i=1 on the load cycle, the low two address bits follow base XOR count.
- R7: bwe_ni[l]=0 on a write command cycle updates lane l, which is bits [l*LANE_W +: LANE_W] of the word. All lanes low writes the full word.
- R8: A read issued on the cycle right after a write to the same address returns the merged new data, including partial-lane writes.
- R9: sleep_i=1 turns the cycle into a no-op whatever the other inputs are, and ends a burst.
- R10: Read data and rvalid_o=1 appear after the second enabled edge following the read command edge.
- R11: Write data is sampled on wdata_i at the second enabled edge after the write command. In any output cycle that delivers no read data, rvalid_o is 0 and rdata_o is zero.
- R12: An advance cycle with no active burst (after reset, deselect or sleep) is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| rd_i | input | 1 | Command direction: 1 read, 0 write |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 continues the burst, 0 loads a new command |
| ilv_i | input | 1 | Burst order on load: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Turns the cycle into a no-op |
| bwe_ni | input | DATA_W/LANE_W | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, sampled two enabled edges after its command |
| rdata_o | output | DATA_W | Registered read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions assume that the inputs are stable around each rising edge and that wdata_i is meaningful only on the edge that samples it. The output checks also assume that each read targets a word written earlier. The bench writes every address once before any read, so read data is never undefined. After that it changes inputs only on falling edges, mixing stalls, deselects and sleeps into the random traffic.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;

  function automatic logic [1:0] burst_lsb(logic [1:0] base, logic [1:0] cnt, logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl import zbt_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              rd_i,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              cs3_ni,
  input  logic              adv_i,
  input  logic              ilv_i,
  input  logic              sleep_i,
  input  logic [LANES-1:0]  bwe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              a_vld_o,
  output op_e               a_op_o,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic              b_vld_o,
  output op_e               b_op_o,
  output logic [ADDR_W-1:0] b_addr_o,
  output logic [LANES-1:0]  b_bwe_o
);
  logic              bst_act, bst_ilv;
  op_e               bst_op;
  logic [1:0]        bst_cnt, nxt_cnt;
  logic [ADDR_W-1:0] bst_base, cont_addr;
  logic [LANES-1:0]  a_bwe;
  logic              sel, load, cont;

  always_comb begin
    sel       = !sleep_i && !cs1_ni && cs2_i && !cs3_ni;
    load      = sel && !adv_i;
    cont      = sel && adv_i && bst_act;
    nxt_cnt   = bst_cnt + 2'd1;
    cont_addr = {bst_base[ADDR_W-1:2], burst_lsb(bst_base[1:0], nxt_cnt, bst_ilv)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_o  <= 1'b0;
      a_op_o   <= OP_WR;
      a_addr_o <= '0;
      a_bwe    <= '1;
      b_vld_o  <= 1'b0;
      b_op_o   <= OP_WR;
      b_addr_o <= '0;
      b_bwe_o  <= '1;
      bst_act  <= 1'b0;
      bst_ilv  <= 1'b0;
      bst_op   <= OP_WR;
      bst_cnt  <= '0;
      bst_base <= '0;
    end else if (!cke_ni) begin
      a_vld_o  <= load || cont;
      a_op_o   <= load ? op_e'(rd_i) : bst_op;
      a_addr_o <= load ? addr_i : cont_addr;
      a_bwe    <= bwe_ni;
      b_vld_o  <= a_vld_o;
      b_op_o   <= a_op_o;
      b_addr_o <= a_addr_o;
      b_bwe_o  <= a_bwe;
      if (load) begin
        bst_act  <= 1'b1;
        bst_base <= addr_i;
        bst_cnt  <= '0;
        bst_ilv  <= ilv_i;
        bst_op   <= op_e'(rd_i);
      end else if (cont) begin
        bst_cnt  <= nxt_cnt;
      end else begin
        bst_act  <= 1'b0;
      end
    end
  end

  assert_deselect_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && (cs1_ni || !cs2_i || cs3_ni)) |=> !a_vld_o);
  assert_sleep_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && sleep_i) |=> !a_vld_o);
  assert_burst_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && cont) |=> (a_addr_o[ADDR_W-1:2] == $past(bst_base[ADDR_W-1:2])));
  assert_orphan_adv_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_i && !bst_act) |=> !a_vld_o);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     cke_ni,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W/LANE_W-1:0] wbe_ni,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write on a same-edge collision; zbt_out forwards that case
  always_ff @(posedge clk_i) begin
    if (!cke_ni) begin
      if (re_i) rdata_o <= mem[raddr_i];
      if (we_i) begin
        for (int l = 0; l < LANES; l++) begin
          if (!wbe_ni[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
        end
      end
    end
  end
endmodule

// File: rtl/zbt_out.sv
module zbt_out import zbt_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cke_ni,
  input  logic                     b_vld_i,
  input  op_e                      b_op_i,
  input  logic [ADDR_W-1:0]        b_addr_i,
  input  logic [DATA_W/LANE_W-1:0] b_bwe_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W-1:0]        array_q_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic              fw_vld;
  logic [ADDR_W-1:0] fw_addr;
  logic [LANES-1:0]  fw_bwe, hit;
  logic [DATA_W-1:0] fw_data, merged;
  logic              rd_now;

  assign rd_now = b_vld_i && (b_op_i == OP_RD);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = fw_vld && (fw_addr == b_addr_i) && !fw_bwe[l];
    assign merged[l*LANE_W +: LANE_W] = hit[l] ? fw_data[l*LANE_W +: LANE_W]
                                               : array_q_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw_vld   <= 1'b0;
      fw_addr  <= '0;
      fw_bwe   <= '1;
      fw_data  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else if (!cke_ni) begin
      fw_vld   <= b_vld_i && (b_op_i == OP_WR);
      fw_addr  <= b_addr_i;
      fw_bwe   <= b_bwe_i;
      fw_data  <= wdata_i;
      rvalid_o <= rd_now;
      rdata_o  <= rd_now ? merged : '0;
    end
  end

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(rvalid_o) && $stable(rdata_o)));
  assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && b_vld_i && b_op_i == OP_RD) |=> rvalid_o);
  assert_quiet_output_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !(b_vld_i && b_op_i == OP_RD)) |=> (!rvalid_o && rdata_o == '0));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram import zbt_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cke_ni,
  input  logic                     rd_i,
  input  logic                     cs1_ni,
  input  logic                     cs2_i,
  input  logic                     cs3_ni,
  input  logic                     adv_i,
  input  logic                     ilv_i,
  input  logic                     sleep_i,
  input  logic [DATA_W/LANE_W-1:0] bwe_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic              a_vld, b_vld;
  op_e               a_op, b_op;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [LANES-1:0]  b_bwe;
  logic [DATA_W-1:0] array_q;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .cke_ni, .rd_i, .cs1_ni, .cs2_i, .cs3_ni,
    .adv_i, .ilv_i, .sleep_i, .bwe_ni, .addr_i,
    .a_vld_o(a_vld), .a_op_o(a_op), .a_addr_o(a_addr),
    .b_vld_o(b_vld), .b_op_o(b_op), .b_addr_o(b_addr), .b_bwe_o(b_bwe)
  );

  zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk_i, .cke_ni,
    .re_i(a_vld && a_op == OP_RD), .raddr_i(a_addr),
    .we_i(b_vld && b_op == OP_WR), .waddr_i(b_addr),
    .wbe_ni(b_bwe), .wdata_i, .rdata_o(array_q)
  );

  zbt_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_out (
    .clk_i, .rst_ni, .cke_ni,
    .b_vld_i(b_vld), .b_op_i(b_op), .b_addr_i(b_addr), .b_bwe_i(b_bwe),
    .wdata_i, .array_q_i(array_q), .rdata_o, .rvalid_o
  );
endmodule

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n = 1'b0, rd = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic adv = 1'b0, ilv = 1'b0, sleep = 1'b0;
  logic [NL-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  logic ma_v = 0, ma_rd = 0, mb_v = 0, mb_rd = 0;
  logic [AW-1:0] ma_a = '0, mb_a = '0;
  logic [NL-1:0] ma_be = '1, mb_be = '1;
  logic ms_act = 0, ms_ilv = 0, ms_rd = 0;
  logic [1:0] ms_cnt = '0;
  logic [AW-1:0] ms_base = '0;
  logic exp_v = 0;
  logic [DW-1:0] exp_d = '0;

  always #4 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) u_zbt_sram (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .rd_i(rd), .cs1_ni(cs1_n),
    .cs2_i(cs2), .cs3_ni(cs3_n), .adv_i(adv), .ilv_i(ilv), .sleep_i(sleep),
    .bwe_ni(bwe_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [1:0] beat_lsb(logic [1:0] b, logic [1:0] c, logic il);
    return il ? (b ^ c) : 2'((b + c) & 2'b11);
  endfunction

  task automatic check();
    checks++;
    if (rvalid !== exp_v || rdata !== exp_d) begin
      errors++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, exp_v, exp_d);
    end
  endtask

  task automatic tick();
    logic sel, nv, nrd;
    logic [AW-1:0] na;
    wdata = {$urandom, $urandom};
    @(posedge clk);
    @(negedge clk);
    if (!cke_n) begin
      if (mb_v && mb_rd) begin exp_v = 1; exp_d = ref_mem[mb_a]; end
      else begin exp_v = 0; exp_d = '0; end
      if (mb_v && !mb_rd)
        for (int l = 0; l < NL; l++)
          if (!mb_be[l]) ref_mem[mb_a][l*LW +: LW] = wdata[l*LW +: LW];
      sel = !sleep && !cs1_n && cs2 && !cs3_n;
      nv = 0; nrd = 0; na = '0;
      if (sel && !adv) begin
        nv = 1; nrd = rd; na = addr;
        ms_act = 1; ms_base = addr; ms_cnt = 0; ms_ilv = ilv; ms_rd = rd;
      end else if (sel && adv && ms_act) begin
        ms_cnt = ms_cnt + 2'd1;
        nv = 1; nrd = ms_rd;
        na = {ms_base[AW-1:2], beat_lsb(ms_base[1:0], ms_cnt, ms_ilv)};
      end else begin
        ms_act = 0;
      end
      mb_v = ma_v; mb_rd = ma_rd; mb_a = ma_a; mb_be = ma_be;
      ma_v = nv; ma_rd = nrd; ma_a = na; ma_be = bwe_n;
    end
    check();
  endtask

  task automatic cmd(input logic r, input logic [AW-1:0] a, input logic ad,
                     input logic [NL-1:0] be, input logic il);
    cke_n = 0; sleep = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
    rd = r; addr = a; adv = ad; bwe_n = be; ilv = il;
    tick();
  endtask

  task automatic nop();
    cke_n = 0; sleep = 0; cs1_n = 1; cs2 = 1; cs3_n = 0; adv = 0; rd = 1;
    tick();
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; check();

    tag = "R12"; cke_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; adv = 1; rd = 0; tick();
    nop(); nop();

    tag = "R7";
    for (int a = 0; a < DEPTH; a++) cmd(0, AW'(a), 0, '0, 0);
    nop(); nop();

    tag = "R10"; cmd(1, 8'd3, 0, '1, 0); nop(); nop(); nop();
    tag = "R11"; cmd(0, 8'd4, 0, '0, 0); nop(); nop(); cmd(1, 8'd4, 0, '1, 0); nop(); nop();

    tag = "R8";
    cmd(0, 8'd10, 0, 4'b1010, 0); cmd(1, 8'd10, 0, '1, 0);
    cmd(0, 8'd11, 0, '0, 0); cmd(1, 8'd11, 0, '1, 0); nop(); nop();

    tag = "R7"; cmd(0, 8'd20, 0, 4'b0110, 0); nop(); cmd(1, 8'd20, 0, '1, 0); nop(); nop();

    tag = "R5";
    cmd(1, 8'h21, 0, '1, 0);
    for (int i = 0; i < 5; i++) cmd(1, 8'h00, 1, '1, 0);
    cmd(0, 8'h36, 0, '0, 0);
    for (int i = 0; i < 3; i++) cmd(1, 8'h00, 1, '0, 0);
    cmd(1, 8'h36, 0, '1, 0);
    for (int i = 0; i < 3; i++) cmd(0, 8'h00, 1, '1, 0);
    nop(); nop();

    tag = "R6";
    cmd(1, 8'h46, 0, '1, 1);
    for (int i = 0; i < 5; i++) cmd(1, 8'h00, 1, '1, 0);
    nop(); nop();

    tag = "R4";
    cmd(1, 8'd30, 0, '1, 0);
    cke_n = 1; tick(); tick(); tick();
    nop(); nop(); nop();

    tag = "R3";
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b010) continue;
      cke_n = 0; sleep = 0; rd = 0; adv = 0; addr = 8'd40; bwe_n = '0;
      {cs1_n, cs2, cs3_n} = 3'(c);
      tick();
      cmd(1, 8'd40, 0, '1, 0); nop(); nop();
    end

    tag = "R9";
    cmd(1, 8'd50, 0, '1, 0);
    cs1_n = 0; cs2 = 1; cs3_n = 0; sleep = 1; rd = 0; adv = 0; addr = 8'd41; bwe_n = '0; tick();
    sleep = 1; adv = 1; tick();
    sleep = 0; adv = 1; tick();
    cmd(1, 8'd41, 0, '1, 0); nop(); nop();

    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      cke_n = ($urandom % 8) == 0;
      sleep = ($urandom % 32) == 0;
      if (($urandom % 8) == 0) {cs1_n, cs2, cs3_n} = 3'($urandom);
      else {cs1_n, cs2, cs3_n} = 3'b010;
      adv = ($urandom % 3) == 0;
      rd = 1'($urandom);
      ilv = 1'($urandom);
      bwe_n = ($urandom % 2) ? '0 : NL'($urandom);
      addr = ($urandom % 4 == 0) ? AW'($urandom % 4) : AW'($urandom);
      tick();
    end
    nop(); nop(); nop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule